// File: doc/BRIEF.md
# Parenthesis-Form Truth-Table Evaluator

This block reads a two-variable boundary-logic expression, one ASCII character per cycle, and works out its whole truth table in a single pass. A mark is written as a pair of parentheses. Its value is the NOR of everything it encloses. Items written next to each other at the same level are ORed together. The letters `a` and `b` name the two inputs.

All four input combinations are evaluated together. Each nesting level holds a 4-bit accumulator, and the levels form a bounded stack. When a newline arrives, the block pulses `done` for one cycle. In that cycle it presents the 4-bit code of the two-input operator the expression reduces to, together with an error flag.

A producer presents characters under a valid/ready handshake. It can start the next expression on the cycle after `done`.

Top module: `paren_truth_eval`

## Requirements
- R1: An empty mark `()` evaluates to true, which is code 1111. The character `1` is a shorthand for an empty mark and also gives 1111.
- R2: Items at the same level combine by OR, so `ab` gives 0111.
- R3: The result is packed as `result[3]`=v0, `result[2]`=v1, `result[1]`=v2, `result[0]`=v3. Here v0..v3 are the outputs for (a,b) = (0,0), (0,1), (1,0), (1,1). Under this packing `a` alone gives 0011 and `b` alone gives 0101.
- R4: A mark yields the bitwise NOR of its contents. So `(ab)` gives 1000, `((a)(b))` gives 0001, `(a)b` gives 1101 and `(((ab)a)((ab)b))` gives 1001.
- R5: A terminator with nothing before it gives 0000 and no error.
- R6: Space characters (0x20) have no effect on the result or on the error flag.
- R7: Nesting up to DEPTH open marks is accepted without error. Opening mark number DEPTH+1 while DEPTH marks are still open sets the error flag.
- R8: A `)` with no open mark sets the error flag.
- R9: A newline (0x0A) that arrives while marks are still open sets the error flag.
- R10: Any character other than `(`, `)`, `a`, `b`, `1`, space or newline sets the error flag. Once an error is flagged, the remaining characters up to the newline are discarded.
- R11: The cycle after the newline is accepted, `done` is high for exactly one cycle, and `result` and `err` are updated at that point. `in_ready` is low during that cycle and high again on the next. `result` and `err` change only together with `done`.
- R12: A synchronous active-high reset abandons any partial expression and clears the stack and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Character present on `in_char` |
| in_char | input | CW | ASCII character |
| in_ready | output | 1 | Block can take a character this cycle |
| done | output | 1 | One-cycle pulse when an expression completes |
| result | output | 4 | Operator code, v0 in bit 3 down to v3 in bit 0 |
| err | output | 1 | The completed expression was malformed |

## Verification
The bench builds the block with its default DEPTH of 16 and CW of 8. At that depth, sixteen nested marks around `a` reach the top of the stack exactly, and a seventeenth opening overflows it. Both sides of the limit are therefore checked directly. Because the character width is the full byte, illegal characters such as `x` can be presented.

// File: rtl/paren_truth_eval.sv
module paren_truth_eval #(
  parameter int DEPTH = 16,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [CW-1:0] in_char,
  output logic          in_ready,
  output logic          done,
  output logic [3:0]    result,
  output logic          err
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] C_OPEN  = CW'(40);
  localparam logic [CW-1:0] C_CLOSE = CW'(41);
  localparam logic [CW-1:0] C_A     = CW'(97);
  localparam logic [CW-1:0] C_B     = CW'(98);
  localparam logic [CW-1:0] C_ONE   = CW'(49);
  localparam logic [CW-1:0] C_SP    = CW'(32);
  localparam logic [CW-1:0] C_NL    = CW'(10);

  logic [3:0]    stk [DEPTH+1];
  logic [PW-1:0] ptr;
  logic          bad;

  wire          take   = in_valid & in_ready;
  wire [PW-1:0] nxt    = ptr + 1'b1;
  wire [PW-1:0] prv    = ptr - 1'b1;
  wire          at_top = ptr == PW'(DEPTH);
  wire          at_bot = ptr == '0;

  assign in_ready = ~done;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      bad    <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      err    <= 1'b0;
      for (int i = 0; i <= DEPTH; i++) stk[i] <= '0;
    end else begin
      done <= 1'b0;
      if (take) begin
        if (in_char == C_NL) begin
          done   <= 1'b1;
          result <= stk[0];
          err    <= bad | ~at_bot;
          ptr    <= '0;
          bad    <= 1'b0;
          stk[0] <= '0;
        end else if (!bad) begin
          case (in_char)
            C_OPEN:
              if (at_top) bad <= 1'b1;
              else begin
                ptr      <= nxt;
                stk[nxt] <= '0;
              end
            C_CLOSE:
              if (at_bot) bad <= 1'b1;
              else begin
                ptr      <= prv;
                stk[prv] <= stk[prv] | ~stk[ptr];
              end
            C_A:     stk[ptr] <= stk[ptr] | 4'b0011;
            C_B:     stk[ptr] <= stk[ptr] | 4'b0101;
            C_ONE:   stk[ptr] <= 4'b1111;
            C_SP:    ;
            default: bad <= 1'b1;
          endcase
        end
      end
    end
  end

  p_ptr_bound_r7: assert property (@(posedge clk) disable iff (rst)
    ptr <= PW'(DEPTH));
  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_ready_low_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !in_ready);
  p_result_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result) && $stable(err));
  p_stack_clear_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> (ptr == '0) && !bad);
endmodule

// File: tb/tb_paren_truth_eval.sv
module tb_paren_truth_eval;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_char = 8'd0;
  logic       in_ready, done, err;
  logic [3:0] result;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  paren_truth_eval #(.DEPTH(16), .CW(8)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_char(in_char),
    .in_ready(in_ready), .done(done), .result(result), .err(err));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] c);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_char  = c;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(input string s, input string tag,
                     input logic [3:0] exp_r, input logic exp_e, input logic chk_r);
    for (int i = 0; i < s.len(); i++) put(s[i]);
    put(8'd10);
    chk({tag, " done"}, {7'd0, done}, 8'd1);
    chk({tag, " err"}, {7'd0, err}, {7'd0, exp_e});
    if (chk_r) chk({tag, " result"}, {4'd0, result}, {4'd0, exp_r});
  endtask

  task automatic t_basic;
    run("()", "R1 empty mark", 4'b1111, 1'b0, 1'b1);
    run("1", "R1 one", 4'b1111, 1'b0, 1'b1);
    run("ab", "R2 or", 4'b0111, 1'b0, 1'b1);
    run("a", "R3 a", 4'b0011, 1'b0, 1'b1);
    run("b", "R3 b", 4'b0101, 1'b0, 1'b1);
    run("", "R5 empty", 4'b0000, 1'b0, 1'b1);
  endtask

  task automatic t_nor;
    run("(ab)", "R4 nor", 4'b1000, 1'b0, 1'b1);
    run("((a)(b))", "R4 and", 4'b0001, 1'b0, 1'b1);
    run("(a)b", "R4 imp", 4'b1101, 1'b0, 1'b1);
    run("(((ab)a)((ab)b))", "R4 eq", 4'b1001, 1'b0, 1'b1);
    run("((((ab)a)((ab)b)))", "R4 xor", 4'b0110, 1'b0, 1'b1);
  endtask

  task automatic t_space;
    run(" ( a ) b ", "R6 spaces", 4'b1101, 1'b0, 1'b1);
  endtask

  task automatic t_handshake;
    put(8'd10);
    chk("R11 done pulse", {7'd0, done}, 8'd1);
    chk("R11 ready low", {7'd0, in_ready}, 8'd0);
    @(negedge clk);
    chk("R11 done drop", {7'd0, done}, 8'd0);
    chk("R11 ready back", {7'd0, in_ready}, 8'd1);
  endtask

  task automatic t_depth;
    string s = "";
    for (int i = 0; i < 16; i++) s = {s, "("};
    s = {s, "a"};
    for (int i = 0; i < 16; i++) s = {s, ")"};
    run(s, "R7 full depth", 4'b0011, 1'b0, 1'b1);
    s = "";
    for (int i = 0; i < 17; i++) s = {s, "("};
    for (int i = 0; i < 17; i++) s = {s, ")"};
    run(s, "R7 overflow", 4'b0000, 1'b1, 1'b0);
    run("b", "R7 recover", 4'b0101, 1'b0, 1'b1);
  endtask

  task automatic t_errors;
    run("a)", "R8 underflow", 4'b0000, 1'b1, 1'b0);
    run("((a)", "R9 unclosed", 4'b0000, 1'b1, 1'b0);
    run("axb", "R10 illegal", 4'b0000, 1'b1, 1'b0);
    run("a", "R10 recover", 4'b0011, 1'b0, 1'b1);
  endtask

  task automatic t_reset;
    put("(");
    put("(");
    put("a");
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run("b", "R12 reset clears", 4'b0101, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset done", {7'd0, done}, 8'd0);
    chk("R12 reset result", {4'd0, result}, 8'd0);
    chk("R12 reset err", {7'd0, err}, 8'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 ready idle", {7'd0, in_ready}, 8'd1);
    t_basic;
    t_nor;
    t_space;
    t_handshake;
    t_depth;
    t_errors;
    t_reset;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule